// File: doc/BRIEF.md
# Grouped Interrupt Combiner Bank

This block collects level-sensitive interrupt sources in groups of eight and drives one combined interrupt line for each group. Every source has an enable bit. A group's line is raised when at least one of its sources is high and enabled. Four groups share one 32-bit register set, one byte lane each. Register sets are placed 0x10 bytes apart in a small memory-mapped window.

Software changes enable bits through two write-only strobe offsets. One sets bits and the other clears them, so no read-modify-write is needed. Software can read back the enable word and the raw source levels of each set. A helper port takes a group number and returns whether that group has a pending, enabled source, and the bit index of the lowest such source. An interrupt handler can use it to pick the next source without scanning.

Top module: `icb_combiner`

## Requirements
- R1: While reset is asserted and after it, every enable bit is 0. `grp_irq_o`, `sel_valid_o`, `sel_idx_o` and `rd_data_o` are 0 until the first access or source activity changes them.
- R2: A write to offset 0x0 of a register set turns on each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: A write to offset 0x4 of a register set turns off each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: Group g sits in register set g/4 at byte address 0x10*(g/4), in bits [8*(g%4)+7 : 8*(g%4)]. Bit b of group g is input `src_i[8*g+b]`.
- R5: A read at offset 0x0 or 0x4 returns the set's current enable word. Bits of groups that do not exist read 0. Read data appears on `rd_data_o` one cycle after the read request and holds its value until the next read.
- R6: A read at offset 0xC returns the current raw levels of the set's 32 sources, whatever their enable bits are.
- R7: The block does not decode a low nibble other than 0x0, 0x4 or 0xC, nor a set index at or beyond the number of sets. Reads at such addresses return 0. Writes to them change no enable bit.
- R8: `grp_irq_o[g]` equals, one cycle later, the OR of group g's source bits that were both high and enabled. The line drops as soon as the sources drop, because nothing is latched.
- R9: One cycle after `sel_grp_i` is presented, `sel_valid_o` shows whether that group had any high and enabled source. `sel_idx_o` then gives the lowest such bit index, and it is 0 when there is none. A group number at or above `N_GROUPS` gives `sel_valid_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: set index in the upper bits, offset in bits [3:0] |
| req_wdata | input | 32 | Write data (bit mask for set or clear) |
| rd_data_o | output | 32 | Read data, one cycle after a read request |
| src_i | input | 8*N_GROUPS | Level-sensitive interrupt sources |
| grp_irq_o | output | N_GROUPS | Combined interrupt line per group |
| sel_grp_i | input | 5 | Group number inspected by the helper |
| sel_valid_o | output | 1 | Selected group has a pending enabled source |
| sel_idx_o | output | 3 | Lowest pending enabled bit in the selected group |

## Verification
All three results appear one clock after their stimulus: the group lines, the helper outputs and the read data. For the group lines and the helper, "stimulus" means the source levels and the enable state present at the edge. For the read data, it is the read request. The bench drives each stimulus on the falling edge and works out the expected values from its model before the next rising edge, so enable changes written in that cycle are not yet included. It samples one nanosecond after that rising edge. Only then does it apply the cycle's write to its model, so a write shows up in the outputs one cycle later than the write itself.

// File: rtl/icb_pkg.sv
package icb_pkg;

    // Per-group registered state: enable byte and combined line.
    typedef struct packed {
        logic [7:0] en;
        logic       irq;
    } grp_state_t;

    // Top-level registered state: read port and helper result.
    typedef struct packed {
        logic [31:0] rd_data;
        logic        sel_valid;
        logic [2:0]  sel_idx;
    } top_state_t;

    localparam logic [3:0] OFF_EN_SET = 4'h0;
    localparam logic [3:0] OFF_EN_CLR = 4'h4;
    localparam logic [3:0] OFF_STATUS = 4'hC;

endpackage

// File: rtl/icb_lowest8.sv
module icb_lowest8 (
    input  logic [7:0] vec_i,
    output logic       found_o,
    output logic [2:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = 3'(i);
            end
        end
    end
endmodule

// File: rtl/icb_group.sv
module icb_group
    import icb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] src_i,
    input  logic [7:0] set_mask_i,
    input  logic [7:0] clr_mask_i,
    output logic [7:0] en_o,
    output logic [7:0] pend_o,
    output logic       irq_o
);
    grp_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.en  = (st_q.en | set_mask_i) & ~clr_mask_i;
        st_d.irq = |(src_i & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pend_o = src_i & st_q.en;
    assign irq_o  = st_q.irq;

    // R2: without a clear strobe no enable bit is lost
    a_r2_set_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask_i == 8'h00) |=> ((($past(st_q.en)) & ~st_q.en) == 8'h00));

    // R3: without a set strobe no enable bit appears
    a_r3_clear_adds_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask_i == 8'h00) |=> ((st_q.en & ~($past(st_q.en))) == 8'h00));

    // R8: the combined line is only raised from an enabled group
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(st_q.en) != 8'h00));
endmodule

// File: rtl/icb_combiner.sv
module icb_combiner
    import icb_pkg::*;
#(
    parameter int N_GROUPS = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    output logic [31:0]           rd_data_o,
    input  logic [8*N_GROUPS-1:0] src_i,
    output logic [N_GROUPS-1:0]   grp_irq_o,
    input  logic [4:0]            sel_grp_i,
    output logic                  sel_valid_o,
    output logic [2:0]            sel_idx_o
);
    localparam int NSETS  = (N_GROUPS + 3) / 4;
    localparam int SET_W  = ADDR_W - 4;
    localparam int NLANES = NSETS * 4;

    logic [SET_W-1:0] set_idx;
    logic [3:0]       offset;
    logic             wr_set, wr_clr, rd_req;

    assign set_idx = req_addr[ADDR_W-1:4];
    assign offset  = req_addr[3:0];
    assign wr_set  = req_valid && req_write && (offset == OFF_EN_SET);
    assign wr_clr  = req_valid && req_write && (offset == OFF_EN_CLR);
    assign rd_req  = req_valid && !req_write;

    logic [NLANES-1:0][7:0]   en_lane;
    logic [NLANES-1:0][7:0]   raw_lane;
    logic [N_GROUPS-1:0][7:0] pend_grp;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        localparam int S = g / 4;
        localparam int L = g % 4;
        logic [7:0] set_m, clr_m;
        assign set_m = (wr_set && set_idx == SET_W'(S)) ? req_wdata[8*L +: 8] : 8'h00;
        assign clr_m = (wr_clr && set_idx == SET_W'(S)) ? req_wdata[8*L +: 8] : 8'h00;
        assign raw_lane[g] = src_i[8*g +: 8];
        icb_group u_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_i[8*g +: 8]),
            .set_mask_i (set_m),
            .clr_mask_i (clr_m),
            .en_o       (en_lane[g]),
            .pend_o     (pend_grp[g]),
            .irq_o      (grp_irq_o[g])
        );
    end

    for (genvar p = N_GROUPS; p < NLANES; p++) begin : g_pad
        assign en_lane[p]  = 8'h00;
        assign raw_lane[p] = 8'h00;
    end

    logic [7:0] sel_byte;
    logic       sel_found;
    logic [2:0] sel_low;

    always_comb begin
        sel_byte = 8'h00;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (sel_grp_i == 5'(g)) sel_byte = pend_grp[g];
        end
    end

    icb_lowest8 u_low (
        .vec_i   (sel_byte),
        .found_o (sel_found),
        .idx_o   (sel_low)
    );

    top_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sel_valid = sel_found;
        st_d.sel_idx   = sel_found ? sel_low : 3'd0;
        if (rd_req) begin
            st_d.rd_data = '0;
            for (int s = 0; s < NSETS; s++) begin
                if (set_idx == SET_W'(s)) begin
                    case (offset)
                        OFF_EN_SET, OFF_EN_CLR:
                            st_d.rd_data = {en_lane[4*s+3], en_lane[4*s+2],
                                            en_lane[4*s+1], en_lane[4*s]};
                        OFF_STATUS:
                            st_d.rd_data = {raw_lane[4*s+3], raw_lane[4*s+2],
                                            raw_lane[4*s+1], raw_lane[4*s]};
                        default: st_d.rd_data = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o   = st_q.rd_data;
    assign sel_valid_o = st_q.sel_valid;
    assign sel_idx_o   = st_q.sel_idx;

    // R5: read data holds when no read is requested
    a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data_o));

    // R7: the unused offset 0x8 reads as zero
    a_r7_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && offset == 4'h8) |=> (rd_data_o == 32'h0));

    // R9: a group number out of range never reports a pending source
    a_r9_bad_group_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_grp_i) >= N_GROUPS) |=> !sel_valid_o);

    // R9: no valid report means index 0
    a_r9_idx_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid_o |-> (sel_idx_o == 3'd0));
endmodule

// File: tb/icb_combiner_test.sv
module icb_combiner_test;
    localparam int N_GROUPS = 8;
    localparam int ADDR_W   = 8;
    localparam int NSETS    = (N_GROUPS + 3) / 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0]     req_addr = '0;
    logic [31:0]           req_wdata = '0;
    logic [31:0]           rd_data_o;
    logic [8*N_GROUPS-1:0] src_i = '0;
    logic [N_GROUPS-1:0]   grp_irq_o;
    logic [4:0]            sel_grp_i = '0;
    logic                  sel_valid_o;
    logic [2:0]            sel_idx_o;

    always #2 clk = ~clk;

    icb_combiner #(.N_GROUPS(N_GROUPS), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data_o(rd_data_o),
        .src_i(src_i), .grp_irq_o(grp_irq_o), .sel_grp_i(sel_grp_i),
        .sel_valid_o(sel_valid_o), .sel_idx_o(sel_idx_o)
    );

    logic [7:0]  m_en [N_GROUPS];
    logic [31:0] m_rd;
    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] read_exp(input logic [7:0] a, input logic [8*N_GROUPS-1:0] s);
        int set = int'(a[7:4]);
        logic [31:0] w = '0;
        if (set >= NSETS) return '0;
        if (a[3:0] == 4'h0 || a[3:0] == 4'h4) begin
            for (int l = 0; l < 4; l++)
                if (4*set + l < N_GROUPS) w[8*l +: 8] = m_en[4*set + l];
            return w;
        end
        if (a[3:0] == 4'hC) return s[32*set +: 32];
        return '0;
    endfunction

    function automatic logic [N_GROUPS-1:0] irq_exp(input logic [8*N_GROUPS-1:0] s);
        logic [N_GROUPS-1:0] r;
        for (int g = 0; g < N_GROUPS; g++) r[g] = |(s[8*g +: 8] & m_en[g]);
        return r;
    endfunction

    function automatic logic [3:0] sel_exp(input logic [4:0] grp, input logic [8*N_GROUPS-1:0] s);
        logic [7:0] v;
        if (int'(grp) >= N_GROUPS) return 4'h0;
        v = s[8*int'(grp) +: 8] & m_en[grp];
        for (int b = 0; b < 8; b++) if (v[b]) return {1'b1, 3'(b)};
        return 4'h0;
    endfunction

    task automatic step(input logic v, input logic w, input logic [7:0] a, input logic [31:0] d,
                        input logic [8*N_GROUPS-1:0] s, input logic [4:0] grp, input string tag);
        logic [N_GROUPS-1:0] e_irq;
        logic [3:0] e_sel;
        int set;
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; src_i = s; sel_grp_i = grp;
        e_irq = irq_exp(s);
        e_sel = sel_exp(grp, s);
        if (v && !w) m_rd = read_exp(a, s);
        @(posedge clk);
        #1;
        check("R8", 32'(grp_irq_o), 32'(e_irq));
        check("R9", {28'h0, sel_valid_o, sel_idx_o}, {28'h0, e_sel});
        check(tag, rd_data_o, m_rd);
        set = int'(a[7:4]);
        if (v && w && set < NSETS) begin
            for (int l = 0; l < 4; l++) begin
                if (4*set + l < N_GROUPS) begin
                    if (a[3:0] == 4'h0) m_en[4*set+l] = m_en[4*set+l] | d[8*l +: 8];
                    if (a[3:0] == 4'h4) m_en[4*set+l] = m_en[4*set+l] & ~d[8*l +: 8];
                end
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [8*N_GROUPS-1:0] s;
        logic [7:0] a;
        void'($urandom(32'd20240611));
        for (int g = 0; g < N_GROUPS; g++) m_en[g] = 8'h00;
        m_rd = '0;
        src_i = {8*N_GROUPS{1'b1}};
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs idle during reset
        check("R1", 32'(grp_irq_o), 32'h0);
        check("R1", {28'h0, sel_valid_o, sel_idx_o}, 32'h0);
        check("R1", rd_data_o, 32'h0);
        @(negedge clk); rst_n = 1'b1; src_i = '0;
        // R1: enables read 0 after reset, all sources high give no line
        step(1, 0, 8'h00, 0, {8*N_GROUPS{1'b1}}, 5'd0, "R1");
        step(1, 0, 8'h14, 0, {8*N_GROUPS{1'b1}}, 5'd5, "R1");
        // R2: set bits, zero bits keep
        step(1, 1, 8'h00, 32'h0000_0101, '0, 5'd0, "R2");
        step(1, 1, 8'h00, 32'h0000_0002, '0, 5'd0, "R2");
        step(1, 0, 8'h04, 0, 64'h0000_0000_0000_0100, 5'd1, "R2");
        // R4: group 7 is top byte of set 1 at 0x10
        step(1, 1, 8'h10, 32'hFF00_0000, '0, 5'd7, "R4");
        step(1, 0, 8'h10, 0, 64'h4800_0000_0000_0000, 5'd7, "R4");
        step(0, 0, 8'h00, 0, 64'h4800_0000_0000_0000, 5'd7, "R9");
        // R3: clear bits, zero mask no effect
        step(1, 1, 8'h04, 32'h0000_0001, '0, 5'd0, "R3");
        step(1, 1, 8'h14, 32'h0000_0000, '0, 5'd0, "R3");
        step(1, 0, 8'h00, 0, 64'h0000_0000_0000_0003, 5'd0, "R3");
        step(1, 0, 8'h10, 0, '0, 5'd0, "R3");
        // R6: status shows raw levels even when disabled
        step(1, 0, 8'h0C, 0, 64'h1234_5678_9ABC_DEF0, 5'd2, "R6");
        step(1, 0, 8'h1C, 0, 64'h1234_5678_9ABC_DEF0, 5'd2, "R6");
        // R5: data holds without read
        step(0, 0, 8'h00, 0, '0, 5'd2, "R5");
        // R7: holes read 0, writes there ignored
        step(1, 0, 8'h08, 0, '1, 5'd0, "R7");
        step(1, 1, 8'h08, 32'hFFFF_FFFF, '0, 5'd0, "R7");
        step(1, 1, 8'h20, 32'hFFFF_FFFF, '0, 5'd0, "R7");
        step(1, 1, 8'h01, 32'hFFFF_FFFF, '0, 5'd0, "R7");
        step(1, 0, 8'h00, 0, '0, 5'd0, "R7");
        step(1, 0, 8'h20, 0, '1, 5'd0, "R7");
        // R9: group number out of range
        step(0, 0, 8'h00, 0, '1, 5'd9, "R9");
        // R8: level drops with source
        step(0, 0, 8'h00, 0, 64'h8000_0000_0000_0000, 5'd7, "R8");
        step(0, 0, 8'h00, 0, '0, 5'd7, "R8");
        for (int i = 0; i < 3000; i++) begin
            case ($urandom % 6)
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h0C;
                3: a = 8'h10 | 8'($urandom % 4) * 8'h4;
                4: a = 8'h08;
                default: a = 8'($urandom % 48);
            endcase
            s = {$urandom, $urandom} & {$urandom, $urandom};
            step(($urandom % 4) != 0, ($urandom % 2) != 0, a, $urandom, s,
                 5'($urandom % 10), "R5");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule